// File: doc/BRIEF.md
# Qualified Capture Sequencer

This block decides, cycle by cycle, which samples go into an external capture buffer of fixed depth. Software or a debug controller sets a mode and pulses an arm input. In immediate mode storing begins on the cycle after arming. In trigger mode the block first waits for a trigger-match pulse from an external comparator. An optional qualify gate then admits only those cycles on which an external condition evaluator reports a hit. The qualify gate and the trigger are evaluated separately. The trigger marks where the capture window opens. The qualify input filters the samples inside that window.

Each stored word holds the sample and a timestamp. The timestamp counts every cycle since the capture window opened, so the gaps that filtering leaves can be rebuilt later. When the last buffer slot is written, the block stops and holds a done flag until it is armed again. One configuration is refused: trigger mode with the trigger disabled. For that request the block raises an error flag and stays idle.

Top module: `capture_sequencer`

## Requirements
- R1: After reset the block is idle: `wr_en`, `done`, `waiting`, `capturing` and `cfg_err` are all 0.
- R2: With `mode_trig`=0 and `qual_en`=0 at arming, one sample is written on every cycle from the cycle after the arm pulse. Addresses run 0,1,2,... and `wr_data[DATA_W-1:0]` equals that cycle's `sample_in`.
- R3: In immediate mode, `trig_en` and `trig_hit` have no effect on which cycles are written.
- R4: When `qual_en` was 1 at arming, a cycle is written only if `qual_hit` is 1 in that same cycle. This holds in both modes.
- R5: In trigger mode nothing is written while waiting until `trig_hit` is 1. The cycle on which `trig_hit` is 1 is itself a candidate for writing, still subject to R4. `waiting` is 1 during the wait.
- R6: `wr_addr` advances by one only on written cycles. The cycle after the write at address DEPTH-1, `done` becomes 1. While `done` is 1, no write occurs, and `done` stays 1 until the next arm.
- R7: `wr_data[DATA_W+TS_W-1:DATA_W]` holds a timestamp. It is 0 on the first candidate cycle of the window (the first capturing cycle in immediate mode, the trigger cycle in trigger mode) and rises by one on every later cycle, whether or not that cycle is written.
- R8: An arm with `mode_trig`=1 and `trig_en`=0 sets `cfg_err` on the next cycle, leaves the block idle and writes nothing. The next valid arm clears `cfg_err`.
- R9: `mode_trig`, `qual_en` and `trig_en` are sampled only when an arm is accepted. An arm is accepted only when the block is idle or done. While `waiting` or `capturing`, both a new arm and changes to the configuration inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start pulse |
| mode_trig | input | 1 | 0 = immediate, 1 = wait for trigger |
| qual_en | input | 1 | Gate each write with `qual_hit` |
| trig_en | input | 1 | Trigger comparator configured |
| trig_hit | input | 1 | Trigger comparator match this cycle |
| qual_hit | input | 1 | Qualify condition true this cycle |
| sample_in | input | DATA_W | Sample to store |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | AW | Buffer write address |
| wr_data | output | TS_W+DATA_W | {timestamp, sample} |
| done | output | 1 | Buffer full, capture finished |
| waiting | output | 1 | Armed in trigger mode, waiting for trigger |
| capturing | output | 1 | Capture window open |
| cfg_err | output | 1 | Last arm was refused as invalid |

## Verification
The delicate coincidence is the trigger and the qualify gate landing on the same cycle. The bench fires `trig_hit` once with `qual_hit` low and once with it high. It checks that the trigger cycle opens the window and sets the timestamp origin in both cases, but is stored only in the second. A second coincidence is the final write next to a re-arm attempt in the same window: an arm is driven while capturing and again right after `done`. A behavioural model predicts every output on every cycle, and the model's state decides whether the arm takes effect.

// File: rtl/capture_sequencer.sv
module capture_sequencer #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int TS_W   = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   arm,
  input  logic                   mode_trig,
  input  logic                   qual_en,
  input  logic                   trig_en,
  input  logic                   trig_hit,
  input  logic                   qual_hit,
  input  logic [DATA_W-1:0]      sample_in,
  output logic                   wr_en,
  output logic [AW-1:0]          wr_addr,
  output logic [TS_W+DATA_W-1:0] wr_data,
  output logic                   done,
  output logic                   waiting,
  output logic                   capturing,
  output logic                   cfg_err
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_CAP, S_DONE} st_t;

  st_t             st;
  logic            qual_q;
  logic            err_q;
  logic [AW-1:0]   addr_q;
  logic [TS_W-1:0] ts_q;

  wire can_arm  = (st == S_IDLE) || (st == S_DONE);
  wire bad_cfg  = mode_trig && !trig_en;
  wire trig_now = (st == S_WAIT) && trig_hit;
  wire live     = (st == S_CAP) || trig_now;
  wire pass     = !qual_q || qual_hit;
  wire last     = wr_en && (addr_q == LAST);

  assign wr_en     = live && pass;
  assign wr_addr   = addr_q;
  assign wr_data   = {ts_q, sample_in};
  assign done      = (st == S_DONE);
  assign waiting   = (st == S_WAIT);
  assign capturing = (st == S_CAP);
  assign cfg_err   = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      qual_q <= 1'b0;
      err_q  <= 1'b0;
      addr_q <= '0;
      ts_q   <= '0;
    end else if (can_arm && arm) begin
      err_q <= bad_cfg;
      if (bad_cfg) begin
        st <= S_IDLE;
      end else begin
        qual_q <= qual_en;
        addr_q <= '0;
        ts_q   <= '0;
        st     <= mode_trig ? S_WAIT : S_CAP;
      end
    end else begin
      if (live)  ts_q   <= ts_q + 1'b1;
      if (wr_en) addr_q <= last ? '0 : addr_q + 1'b1;
      if (last)          st <= S_DONE;
      else if (trig_now) st <= S_CAP;
    end
  end
endmodule

module capture_sequencer_chk #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int TS_W   = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   trig_hit,
  input logic                   wr_en,
  input logic [AW-1:0]          wr_addr,
  input logic [TS_W+DATA_W-1:0] wr_data,
  input logic                   done,
  input logic                   waiting,
  input logic                   capturing,
  input logic                   cfg_err
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  wire [TS_W-1:0] ts = wr_data[DATA_W +: TS_W];

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!waiting && !capturing) |-> !wr_en);
  assert_wait_needs_trig_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && wr_en) |-> trig_hit);
  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != LAST) |=> (wr_addr == $past(wr_addr) + 1'b1));
  assert_last_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == LAST) |=> done);
  assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en);
  assert_ts_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    capturing |=> (!capturing || ts == $past(ts) + 1'b1));
  assert_err_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!waiting && !capturing && !done));
endmodule

bind capture_sequencer capture_sequencer_chk #(
  .DEPTH(DEPTH), .DATA_W(DATA_W), .TS_W(TS_W)
) u_chk (.*);

// File: tb/capture_sequencer_bench.sv
`timescale 1ns/1ps
module capture_sequencer_bench;
  localparam int DEPTH = 8, DW = 8, TSW = 12, AW = 3;

  logic clk = 0, rst_n = 0;
  logic arm = 0, mode_trig = 0, qual_en = 0, trig_en = 0, trig_hit = 0, qual_hit = 0;
  logic [DW-1:0] sample_in = '0;
  logic wr_en, done, waiting, capturing, cfg_err;
  logic [AW-1:0] wr_addr;
  logic [TSW+DW-1:0] wr_data;

  always #10 clk = ~clk;

  capture_sequencer #(.DEPTH(DEPTH), .DATA_W(DW), .TS_W(TSW)) u_capture_sequencer (.*);

  int checks = 0, failures = 0;
  bit finished = 0;

  // behavioural model: phase 0 idle, 1 waiting, 2 capturing, 3 done
  int m_phase = 0, m_addr = 0, m_ts = 0;
  bit m_err = 0, m_qe = 0;

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(string tag, bit a, bit m, bit qe, bit te, bit th, bit qh, logic [DW-1:0] d);
    bit we;
    logic [TSW+DW-1:0] exp_data;
    @(negedge clk);
    arm = a; mode_trig = m; qual_en = qe; trig_en = te; trig_hit = th; qual_hit = qh; sample_in = d;
    #1;
    we = ((m_phase == 2) || (m_phase == 1 && th)) && (!m_qe || qh);
    exp_data = {m_ts[TSW-1:0], d};
    chk(tag, "wr_en", wr_en, we);
    if (we) begin
      chk(tag, "wr_addr", wr_addr, m_addr);
      chk(tag, "wr_data", wr_data, exp_data);
    end
    chk(tag, "done", done, m_phase == 3);
    chk(tag, "waiting", waiting, m_phase == 1);
    chk(tag, "capturing", capturing, m_phase == 2);
    chk(tag, "cfg_err", cfg_err, m_err);
    if ((m_phase == 0 || m_phase == 3) && a) begin
      if (m && !te) begin m_err = 1; m_phase = 0; end
      else begin m_err = 0; m_addr = 0; m_ts = 0; m_qe = qe; m_phase = m ? 1 : 2; end
    end else if (m_phase == 1 || m_phase == 2) begin
      if (m_phase == 2 || th) begin m_ts++; m_phase = 2; end
      if (we) begin
        if (m_addr == DEPTH - 1) begin m_addr = 0; m_phase = 3; end
        else m_addr++;
      end
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: idle after reset
    for (int i = 0; i < 3; i++) cyc("R1", 0, 0, 0, 0, 0, 1, 8'(i));
    // R2: immediate, every cycle stored; then R6 done held
    cyc("R2", 1, 0, 0, 0, 0, 0, 8'hA0);
    for (int i = 0; i < DEPTH; i++) cyc("R2", 0, 0, 0, 0, 0, 0, 8'(8'h10 + i));
    for (int i = 0; i < 4; i++) cyc("R6", 0, 1, 1, 0, 1, 1, 8'(i));
    // R3: immediate ignores trigger settings
    cyc("R3", 1, 0, 0, 0, 0, 0, 8'h33);
    for (int i = 0; i < DEPTH + 2; i++) cyc("R3", 0, 0, 0, i % 2, (i % 3) == 0, 0, 8'(8'h40 + i));
    // R4: immediate with qualification, sparse hits; R7 timestamps show gaps
    cyc("R4", 1, 0, 1, 0, 0, 0, 8'h44);
    for (int i = 0; i < 3 * DEPTH + 3; i++) cyc("R4", 0, 0, 1, 0, 0, (i % 3) == 1, 8'(8'h50 + i));
    // R5: trigger mode, no qual, wait then fire
    cyc("R5", 1, 1, 0, 1, 0, 0, 8'h55);
    for (int i = 0; i < 5; i++) cyc("R5", 0, 1, 0, 1, 0, 1, 8'(8'h60 + i));
    cyc("R5", 0, 1, 0, 1, 1, 0, 8'h6F);
    for (int i = 0; i < DEPTH + 1; i++) cyc("R5", 0, 1, 0, 1, (i % 2) == 0, 0, 8'(8'h70 + i));
    // R7: trigger with qual low on trigger cycle: origin set, not stored
    cyc("R7", 1, 1, 1, 1, 0, 0, 8'h77);
    for (int i = 0; i < 3; i++) cyc("R7", 0, 1, 1, 1, 0, 1, 8'(i));
    cyc("R7", 0, 1, 1, 1, 1, 0, 8'h88);
    for (int i = 0; i < 3 * DEPTH; i++) cyc("R7", 0, 1, 1, 1, 0, (i % 3) != 0, 8'(8'h90 + i));
    // R4 in trigger mode: trigger cycle qualified and stored
    cyc("R4", 1, 1, 1, 1, 0, 0, 8'h11);
    cyc("R4", 0, 1, 1, 1, 1, 1, 8'h12);
    for (int i = 0; i < 2 * DEPTH; i++) cyc("R4", 0, 1, 1, 1, 0, (i % 2) == 0, 8'(8'hB0 + i));
    // R8: invalid config refused, then cleared by valid arm
    cyc("R8", 1, 1, 1, 0, 1, 1, 8'h01);
    for (int i = 0; i < 4; i++) cyc("R8", 0, 1, 1, 0, 1, 1, 8'(i));
    cyc("R8", 1, 1, 0, 1, 0, 0, 8'h02);
    for (int i = 0; i < 3; i++) cyc("R8", 0, 1, 0, 1, 0, 0, 8'(i));
    cyc("R8", 0, 1, 0, 1, 1, 1, 8'hC0);
    for (int i = 0; i < DEPTH; i++) cyc("R8", 0, 1, 0, 1, 0, 1, 8'(8'hC1 + i));
    // R9: config latched at arm; re-arm while capturing ignored
    cyc("R9", 1, 0, 1, 0, 0, 0, 8'h99);
    for (int i = 0; i < 3 * DEPTH; i++)
      cyc("R9", (i % 4) == 1, 1, 0, 0, 1, (i % 2) == 0, 8'(8'hD0 + i));
    cyc("R9", 1, 0, 0, 0, 0, 0, 8'hE0);
    for (int i = 0; i < 3; i++) cyc("R9", 0, 1, 1, 0, 0, 0, 8'(8'hE1 + i));
    finish_run();
  end
endmodule